// File: doc/BRIEF.md
# Aligned Word Load-Store Unit

This unit connects the data side of a simple 32-bit integer core to a memory port that only understands naturally aligned 32-bit words. A store enters as a byte address, a data operand and a size: byte, halfword or word. The unit turns it into a word address with the offset bits cleared, write data steered into the right byte lanes, and a per-lane write mask. Memory lanes whose mask bit is clear keep their old contents.

A load enters with the same address and size and with the whole aligned word that memory returned. The unit cuts out the addressed byte or halfword and widens it to 32 bits. It sign-extends or zero-extends according to an unsigned flag. An instruction fetch address can be aligned in the same cycle through a second, independent path, because the core reads its instruction word in addition to any data access.

Every output is registered, so results appear one clock after the request. When no request is active the data-side outputs are all zero. Misaligned halfword or word accesses raise no trap: the unit ignores the low offset bits that a correctly aligned access would have cleared.

Top module: `lsu_align_top`

## Requirements
- R1: While a data request is registered, `mem_addr` equals the request address with bits [1:0] cleared.
- R2: A byte store (size code 2'b00) drives the low data byte into all four lanes of `mem_wdata` and sets `mem_wmask` to 4'b0001 shifted left by address bits [1:0].
- R3: A halfword store (size code 2'b01) drives the low data halfword into both halves of `mem_wdata` and sets `mem_wmask` to 4'b0011 when address bit 1 is 0, or 4'b1100 when it is 1. Address bit 0 has no effect.
- R4: A word store (size code 2'b10, and also the unused code 2'b11) passes the data through unchanged with `mem_wmask` 4'b1111. Address bits [1:0] have no effect.
- R5: A byte load returns the byte in lane address[1:0] of `mem_rdata`. It is sign-extended when `req_unsigned` is 0 and zero-extended when it is 1.
- R6: A halfword load returns bits [15:0] of `mem_rdata` when address bit 1 is 0, and bits [31:16] when it is 1. It is extended as in R5, and address bit 0 has no effect.
- R7: A word load (size 2'b10 or 2'b11) returns `mem_rdata` unchanged, whatever `req_unsigned` is.
- R8: With `req_valid` low, the registered `mem_valid`, `mem_wen`, `mem_addr`, `mem_wdata`, `mem_wmask`, `load_valid` and `load_data` are all zero. A load gives `mem_wen`, `mem_wmask` and `mem_wdata` of zero, and a store gives `load_valid` and `load_data` of zero.
- R9: `fetch_valid` follows `fetch_req`, and `fetch_addr` is `fetch_pc` with bits [1:0] cleared. It is zero when no fetch is requested, and any data request in the same cycle leaves it unaffected.
- R10: All outputs change one clock after the inputs that cause them. A synchronous active-high reset clears every output to zero, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Data access requested this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| req_unsigned | input | 1 | Zero-extend sub-word loads |
| req_addr | input | 32 | Byte address of the access |
| req_wdata | input | 32 | Store operand, right-aligned |
| mem_rdata | input | 32 | Aligned word read from memory for a load |
| fetch_req | input | 1 | Instruction fetch requested this cycle |
| fetch_pc | input | 32 | Fetch byte address |
| mem_valid | output | 1 | Registered data request strobe |
| mem_wen | output | 1 | Registered write enable |
| mem_addr | output | 32 | Word-aligned data address |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_wmask | output | 4 | Per-byte write enable |
| load_valid | output | 1 | Load result present |
| load_data | output | 32 | Extracted and extended load value |
| fetch_valid | output | 1 | Registered fetch strobe |
| fetch_addr | output | 32 | Word-aligned fetch address |

## Verification
The hardest cases to reach are the ones where ignored address bits must stay ignored. These are a halfword access at an odd offset, a word access at every non-zero offset under both word size codes, and a data access in the same cycle as a fetch from an unaligned address. The stimulus sweeps all four offsets for every size in both directions. It uses load words whose byte and halfword sign bits differ, so that a wrong lane or a wrong extension shows up in the result. Fetches are issued in the same cycle as stores and loads.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WALT = 2'b11
  } size_e;
endpackage

// File: rtl/lsu_word_align.sv
module lsu_word_align #(
  parameter int ADDR_W = 32,
  parameter int NB     = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] aligned_o
);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(NB - 1);

  assign aligned_o = addr_i & ~OFF_MASK;
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NB     = DATA_W / 8,
  parameter int OFF_W  = $clog2(NB)
) (
  input  size_e             size_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] lanes_o,
  output logic [NB-1:0]     mask_o
);
  for (genvar i = 0; i < NB; i++) begin : g_lane
    logic       sel;
    logic [7:0] byte_v;
    always_comb begin
      case (size_i)
        SZ_BYTE: begin
          sel    = (off_i == OFF_W'(i));
          byte_v = data_i[7:0];
        end
        SZ_HALF: begin
          sel    = (off_i[OFF_W-1:1] == (OFF_W-1)'(i / 2));
          byte_v = data_i[8*(i%2) +: 8];
        end
        default: begin
          sel    = 1'b1;
          byte_v = data_i[8*i +: 8];
        end
      endcase
    end
    assign lanes_o[8*i +: 8] = byte_v;
    assign mask_o[i]         = sel;
  end
endmodule

// File: rtl/lsu_load_pick.sv
module lsu_load_pick
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NB     = DATA_W / 8,
  parameter int OFF_W  = $clog2(NB)
) (
  input  size_e             size_i,
  input  logic              uns_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] by_byte, by_half;
  logic [7:0]        b_v;
  logic [15:0]       h_v;

  assign by_byte = word_i >> {off_i, 3'b000};
  assign by_half = word_i >> {off_i[OFF_W-1:1], 4'b0000};
  assign b_v     = by_byte[7:0];
  assign h_v     = by_half[15:0];

  always_comb begin
    case (size_i)
      SZ_BYTE: data_o = {{(DATA_W-8){b_v[7] & ~uns_i}}, b_v};
      SZ_HALF: data_o = {{(DATA_W-16){h_v[15] & ~uns_i}}, h_v};
      default: data_o = word_i;
    endcase
  end
endmodule

// File: rtl/lsu_align_top.sv
module lsu_align_top
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic              req_unsigned,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic              mem_valid,
  output logic              mem_wen,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W/8-1:0] mem_wmask,
  output logic              load_valid,
  output logic [DATA_W-1:0] load_data,
  output logic              fetch_valid,
  output logic [ADDR_W-1:0] fetch_addr
);
  localparam int NB    = DATA_W / 8;
  localparam int OFF_W = $clog2(NB);

  size_e             size_v;
  logic [OFF_W-1:0]  off_v;
  logic [ADDR_W-1:0] data_al, fetch_al;
  logic [DATA_W-1:0] st_lanes, ld_val;
  logic [NB-1:0]     st_mask;
  logic              is_st, is_ld;

  assign size_v = size_e'(req_size);
  assign off_v  = req_addr[OFF_W-1:0];
  assign is_st  = req_valid & req_write;
  assign is_ld  = req_valid & ~req_write;

  lsu_word_align #(.ADDR_W(ADDR_W), .NB(NB)) u_dal (
    .addr_i(req_addr), .aligned_o(data_al));
  lsu_word_align #(.ADDR_W(ADDR_W), .NB(NB)) u_fal (
    .addr_i(fetch_pc), .aligned_o(fetch_al));

  lsu_store_steer #(.DATA_W(DATA_W)) u_st (
    .size_i(size_v), .off_i(off_v), .data_i(req_wdata),
    .lanes_o(st_lanes), .mask_o(st_mask));

  lsu_load_pick #(.DATA_W(DATA_W)) u_ld (
    .size_i(size_v), .uns_i(req_unsigned), .off_i(off_v),
    .word_i(mem_rdata), .data_o(ld_val));

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_valid   <= 1'b0;
      mem_wen     <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      mem_wmask   <= '0;
      load_valid  <= 1'b0;
      load_data   <= '0;
      fetch_valid <= 1'b0;
      fetch_addr  <= '0;
    end else begin
      mem_valid   <= req_valid;
      mem_wen     <= is_st;
      mem_addr    <= req_valid ? data_al : '0;
      mem_wdata   <= is_st ? st_lanes : '0;
      mem_wmask   <= is_st ? st_mask : '0;
      load_valid  <= is_ld;
      load_data   <= is_ld ? ld_val : '0;
      fetch_valid <= fetch_req;
      fetch_addr  <= fetch_req ? fetch_al : '0;
    end
  end
endmodule

// File: rtl/lsu_align_chk.sv
module lsu_align_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              mem_valid,
  input logic              mem_wen,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W/8-1:0] mem_wmask,
  input logic              load_valid,
  input logic [DATA_W-1:0] load_data,
  input logic              fetch_valid,
  input logic [ADDR_W-1:0] fetch_addr
);
  localparam logic [ADDR_W-1:0] LOW = ADDR_W'(DATA_W / 8 - 1);

  a_r1_addr_aligned: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> ((mem_addr & LOW) == '0));

  a_r9_fetch_aligned: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |-> ((fetch_addr & LOW) == '0));

  // R2 R3 R4: a store enables one, two or four lanes
  a_r3_mask_shape: assert property (@(posedge clk) disable iff (rst)
    mem_wen |-> ($countones(mem_wmask) == 1 || $countones(mem_wmask) == 2
                 || $countones(mem_wmask) == 4));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !mem_valid |-> (!mem_wen && mem_wmask == '0 && !load_valid && load_data == '0));

  a_r8_load_no_mask: assert property (@(posedge clk) disable iff (rst)
    !mem_wen |-> (mem_wmask == '0));

  a_r10_latency: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> mem_valid);

  a_r10_reset_clear: assert property (@(posedge clk)
    rst |=> (!mem_valid && !fetch_valid && !load_valid && !mem_wen));
endmodule

bind lsu_align_top lsu_align_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .mem_valid(mem_valid),
  .mem_wen(mem_wen), .mem_addr(mem_addr), .mem_wmask(mem_wmask),
  .load_valid(load_valid), .load_data(load_data),
  .fetch_valid(fetch_valid), .fetch_addr(fetch_addr));

// File: tb/lsu_align_top_tb_top.sv
module lsu_align_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_unsigned = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic [31:0] req_addr = '0, req_wdata = '0, mem_rdata = '0, fetch_pc = '0;
  logic        fetch_req = 1'b0;
  logic        mem_valid, mem_wen, load_valid, fetch_valid;
  logic [31:0] mem_addr, mem_wdata, load_data, fetch_addr;
  logic [3:0]  mem_wmask;

  int checks = 0;
  int errors = 0;

  typedef struct {
    string       tag;
    logic        mv, mw, lv, fv;
    logic [31:0] ma, md, ld, fa;
    logic [3:0]  mm;
  } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lsu_align_top dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_unsigned(req_unsigned), .req_addr(req_addr),
    .req_wdata(req_wdata), .mem_rdata(mem_rdata), .fetch_req(fetch_req),
    .fetch_pc(fetch_pc), .mem_valid(mem_valid), .mem_wen(mem_wen),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wmask(mem_wmask),
    .load_valid(load_valid), .load_data(load_data),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr));

  function automatic logic [31:0] e_wdata(logic [1:0] sz, logic [31:0] d);
    case (sz)
      2'b00:   return {4{d[7:0]}};
      2'b01:   return {2{d[15:0]}};
      default: return d;
    endcase
  endfunction

  function automatic logic [3:0] e_mask(logic [1:0] sz, logic [31:0] a);
    case (sz)
      2'b00:   return 4'b0001 << a[1:0];
      2'b01:   return a[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] e_load(logic [1:0] sz, logic u, logic [31:0] a,
                                         logic [31:0] w);
    logic [7:0]  b;
    logic [15:0] h;
    case (a[1:0])
      2'd0: b = w[7:0];
      2'd1: b = w[15:8];
      2'd2: b = w[23:16];
      default: b = w[31:24];
    endcase
    h = a[1] ? w[31:16] : w[15:0];
    case (sz)
      2'b00:   return u ? {24'h0, b} : {{24{b[7]}}, b};
      2'b01:   return u ? {16'h0, h} : {{16{h[15]}}, h};
      default: return w;
    endcase
  endfunction

  task automatic drive(string tag, logic v, logic wr, logic [1:0] sz, logic u,
                       logic [31:0] a, logic [31:0] d, logic [31:0] rd,
                       logic fr, logic [31:0] pc);
    exp_t e;
    @(negedge clk);
    req_valid = v; req_write = wr; req_size = sz; req_unsigned = u;
    req_addr = a; req_wdata = d; mem_rdata = rd; fetch_req = fr; fetch_pc = pc;
    e.tag = tag;
    e.mv  = v;
    e.mw  = v & wr;
    e.ma  = v ? {a[31:2], 2'b00} : 32'h0;
    e.md  = (v & wr) ? e_wdata(sz, d) : 32'h0;
    e.mm  = (v & wr) ? e_mask(sz, a) : 4'h0;
    e.lv  = v & ~wr;
    e.ld  = (v & ~wr) ? e_load(sz, u, a, rd) : 32'h0;
    e.fv  = fr;
    e.fa  = fr ? {pc[31:2], 2'b00} : 32'h0;
    q.push_back(e);
  endtask

  // monitor: pops one expected item per clock after its capturing edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if ({mem_valid, mem_wen, mem_addr, mem_wdata, mem_wmask, load_valid,
           load_data, fetch_valid, fetch_addr} !==
          {e.mv, e.mw, e.ma, e.md, e.mm, e.lv, e.ld, e.fv, e.fa}) begin
        errors++;
        $display("FAIL %s got v%0b w%0b a%h d%h m%h lv%0b ld%h fv%0b fa%h exp v%0b w%0b a%h d%h m%h lv%0b ld%h fv%0b fa%h",
          e.tag, mem_valid, mem_wen, mem_addr, mem_wdata, mem_wmask, load_valid,
          load_data, fetch_valid, fetch_addr, e.mv, e.mw, e.ma, e.md, e.mm,
          e.lv, e.ld, e.fv, e.fa);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R10: reset wins over active inputs
    req_valid = 1'b1; req_write = 1'b1; req_wdata = 32'hFFFF_FFFF;
    req_addr = 32'h13; fetch_req = 1'b1; fetch_pc = 32'h47;
    repeat (3) @(negedge clk);
    checks++;
    if ({mem_valid, mem_wen, mem_addr, mem_wdata, mem_wmask, load_valid,
         load_data, fetch_valid, fetch_addr} !== '0) begin
      errors++;
      $display("FAIL R10 reset outputs got %h/%h/%h exp all zero",
               mem_addr, mem_wdata, fetch_addr);
    end
    @(negedge clk);
    rst = 1'b0;

    drive("R8 idle", 0, 0, 2'b00, 0, 32'h1234_5677, 32'hDEAD_BEEF, 32'h8888_8888, 0, 0);
    for (int o = 0; o < 4; o++)
      drive("R2 byte store", 1, 1, 2'b00, 0, 32'h0000_1000 + o, 32'hA1B2_C3D4, 32'h0, 0, 0);
    for (int o = 0; o < 4; o++)
      drive("R3 half store", 1, 1, 2'b01, 0, 32'h0000_2000 + o, 32'h5566_E7F8, 32'h0, 0, 0);
    for (int o = 0; o < 4; o++) begin
      drive("R4 word store", 1, 1, 2'b10, 0, 32'h0000_3000 + o, 32'h0BAD_F00D + o, 32'h0, 0, 0);
      drive("R4 word store alt code", 1, 1, 2'b11, 1, 32'h0000_3100 + o, 32'h7E57_0000 + o, 32'h0, 0, 0);
    end
    for (int o = 0; o < 4; o++) begin
      drive("R5 byte load signed", 1, 0, 2'b00, 0, 32'h0000_4000 + o, 32'hFFFF_FFFF, 32'h807F_FF01, 0, 0);
      drive("R5 byte load unsigned", 1, 0, 2'b00, 1, 32'h0000_4000 + o, 32'h0, 32'h807F_FF01, 0, 0);
    end
    for (int o = 0; o < 4; o++) begin
      drive("R6 half load signed", 1, 0, 2'b01, 0, 32'h0000_5000 + o, 32'h0, 32'h8001_7FFE, 0, 0);
      drive("R6 half load unsigned", 1, 0, 2'b01, 1, 32'h0000_5000 + o, 32'h0, 32'h8001_7FFE, 0, 0);
      drive("R6 half load signed neg low", 1, 0, 2'b01, 0, 32'h0000_5100 + o, 32'h0, 32'h1234_F00F, 0, 0);
    end
    for (int o = 0; o < 4; o++) begin
      drive("R7 word load", 1, 0, 2'b10, o[0], 32'h0000_6000 + o, 32'h0, 32'hC0DE_0000 + o, 0, 0);
      drive("R7 word load alt code", 1, 0, 2'b11, ~o[0], 32'h0000_6100 + o, 32'h0, 32'h9ABC_DEF0, 0, 0);
    end
    // R1: high address bits kept, low bits cleared
    drive("R1 high address", 1, 0, 2'b00, 0, 32'hFFFF_FFFF, 32'h0, 32'h0102_0304, 0, 0);
    // R8: idle with live memory word and fetch active
    drive("R8 idle with fetch R9", 0, 1, 2'b00, 0, 32'h0000_7003, 32'h1111_1111, 32'hFFFF_FFFF, 1, 32'h8000_0007);
    // R9: fetch alongside data accesses
    drive("R9 fetch with store", 1, 1, 2'b00, 0, 32'h0000_7001, 32'h0000_00AA, 32'h0, 1, 32'h8000_0102);
    drive("R9 fetch with load", 1, 0, 2'b01, 0, 32'h0000_7003, 32'h0, 32'hFF80_0000, 1, 32'h8000_0FFF);
    drive("R9 no fetch", 1, 1, 2'b10, 0, 32'h0000_7004, 32'h1234_5678, 32'h0, 0, 32'h8000_0FFF);
    drive("R8 back to idle", 0, 0, 2'b00, 0, 32'h0, 32'h0, 32'h0, 0, 0);
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule